// File: doc/BRIEF.md
# Boolean-Mask Relation Evaluator

This block evaluates a relation between two operand words for a processor that keeps no condition flags. Every comparison result leaves the block in one of two forms. A set request returns a whole word that is all ones when the relation holds and all zeros when it does not. That word is meant to be written straight into a general register. A jump request returns a single taken strobe, which the delayed-branch logic uses.

A 4-bit selector picks one of sixteen relations:

- never and always;
- equality and inequality;
- four signed orderings;
- four unsigned orderings;
- four bit-test relations on the bitwise AND of the operands.

The signed and unsigned orderings all come from one shared subtraction, using its carry, sign and overflow. The branch target is computed earlier, in operand decode, by other logic. This unit only supplies the decision in the execution stage. It takes one request per cycle and answers one cycle later.

Top module: `relmask_unit`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `res_valid`, `res_mask` and `br_taken` are all zero.
- R2: A set request (`req_valid`=1, `req_is_jump`=0) produces, on the next clock edge, `res_valid`=1 and a `res_mask` of all ones if the selected relation holds, or all zeros if it does not.
- R3: Selector 0 (never) is always false. Selector 1 (always) is always true.
- R4: Selector 2 is true when `opnd_a` equals `opnd_b`. Selector 3 is true when they differ.
- R5: Selectors 4, 5, 6 and 7 compare the operands as two's-complement numbers: a<b, a<=b, a>b and a>=b, in that order.
- R6: Selectors 8, 9, 10 and 11 compare the operands as unsigned numbers: a<b, a<=b, a>b and a>=b, in that order.
- R7: Let m = a AND b. Selector 12 is true when m is non-zero. Selector 13 is true when m is zero. Selector 14 is true when m equals b. Selector 15 is true when m differs from b.
- R8: A jump request (`req_is_jump`=1) raises `br_taken` for exactly the one cycle after it, and only if the relation holds. During that cycle `res_valid` and `res_mask` are zero.
- R9: A cycle with `req_valid`=0 leaves all three outputs zero on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is present this cycle |
| req_is_jump | input | 1 | 1 = compare-and-jump, 0 = set-conditional |
| req_rel | input | 4 | Relation selector (encoding in R3–R7) |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| res_valid | output | 1 | Mask result present |
| res_mask | output | 32 | All-ones/all-zeros result |
| br_taken | output | 1 | One-cycle branch-taken strobe |

## Verification
The assertions assume that the request inputs are stable and known at each rising edge. They also assume that reset is held for at least one edge before the first request, so that every `$past` refers to a driven cycle.

The bench meets both assumptions. It changes inputs only on falling edges, and it keeps `req_valid` low throughout reset. It then sweeps all sixteen selectors, for both request kinds, over eight boundary operand values: zero, one, all ones, the largest positive value, the most negative value, one above the most negative value, and two alternating bit patterns. Idle cycles are mixed into the sequence.

// File: rtl/relmask_pkg.sv
package relmask_pkg;

    localparam int REL_W = 4;

    typedef enum logic [REL_W-1:0] {
        REL_NEVER  = 4'd0,
        REL_ALWAYS = 4'd1,
        REL_EQ     = 4'd2,
        REL_NE     = 4'd3,
        REL_SLT    = 4'd4,
        REL_SLE    = 4'd5,
        REL_SGT    = 4'd6,
        REL_SGE    = 4'd7,
        REL_ULT    = 4'd8,
        REL_ULE    = 4'd9,
        REL_UGT    = 4'd10,
        REL_UGE    = 4'd11,
        REL_ANY    = 4'd12,
        REL_NONE   = 4'd13,
        REL_ALL    = 4'd14,
        REL_NALL   = 4'd15
    } rel_e;

    typedef struct packed {
        logic zero;     // difference is zero
        logic no_borrow;// carry out of a + ~b + 1
        logic neg;      // sign of difference
        logic ovf;      // signed overflow of the subtraction
    } sub_flags_t;

    typedef struct packed {
        logic any_set;  // (a & b) != 0
        logic covers;   // (a & b) == b
    } bit_flags_t;

endpackage

// File: rtl/relmask_sub.sv
module relmask_sub
    import relmask_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output sub_flags_t       flags
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH:0]   sum;
    logic [WIDTH-1:0] diff;

    always_comb begin
        sum             = {1'b0, a} + {1'b0, ~b} + {{WIDTH{1'b0}}, 1'b1};
        diff            = sum[WIDTH-1:0];
        flags.zero      = (diff == '0);
        flags.no_borrow = sum[WIDTH];
        flags.neg       = diff[MSB];
        flags.ovf       = (a[MSB] != b[MSB]) && (diff[MSB] != a[MSB]);
    end
endmodule

// File: rtl/relmask_bits.sv
module relmask_bits
    import relmask_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output bit_flags_t       flags
);
    logic [WIDTH-1:0] both;

    always_comb begin
        both          = a & b;
        flags.any_set = |both;
        flags.covers  = (both == b);
    end
endmodule

// File: rtl/relmask_select.sv
module relmask_select
    import relmask_pkg::*;
(
    input  logic [REL_W-1:0] rel,
    input  sub_flags_t       sf,
    input  bit_flags_t       bf,
    output logic             holds
);
    logic s_lt;
    logic u_lt;

    always_comb begin
        s_lt = sf.neg ^ sf.ovf;
        u_lt = !sf.no_borrow;
        unique case (rel_e'(rel))
            REL_NEVER:  holds = 1'b0;
            REL_ALWAYS: holds = 1'b1;
            REL_EQ:     holds = sf.zero;
            REL_NE:     holds = !sf.zero;
            REL_SLT:    holds = s_lt;
            REL_SLE:    holds = s_lt || sf.zero;
            REL_SGT:    holds = !(s_lt || sf.zero);
            REL_SGE:    holds = !s_lt;
            REL_ULT:    holds = u_lt;
            REL_ULE:    holds = u_lt || sf.zero;
            REL_UGT:    holds = !(u_lt || sf.zero);
            REL_UGE:    holds = !u_lt;
            REL_ANY:    holds = bf.any_set;
            REL_NONE:   holds = !bf.any_set;
            REL_ALL:    holds = bf.covers;
            REL_NALL:   holds = !bf.covers;
            default:    holds = 1'b0;
        endcase
    end
endmodule

// File: rtl/relmask_unit.sv
module relmask_unit
    import relmask_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_is_jump,
    input  logic [3:0]       req_rel,
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    output logic             res_valid,
    output logic [WIDTH-1:0] res_mask,
    output logic             br_taken
);
    localparam logic [WIDTH-1:0] ONES = {WIDTH{1'b1}};

    typedef struct packed {
        logic             valid;
        logic [WIDTH-1:0] mask;
        logic             taken;
    } out_t;

    sub_flags_t sub_f;
    bit_flags_t bit_f;
    logic       rel_true;
    out_t       st_d, st_q;

    relmask_sub #(.WIDTH(WIDTH)) i_sub (
        .a(opnd_a), .b(opnd_b), .flags(sub_f)
    );

    relmask_bits #(.WIDTH(WIDTH)) i_bits (
        .a(opnd_a), .b(opnd_b), .flags(bit_f)
    );

    relmask_select i_sel (
        .rel(req_rel), .sf(sub_f), .bf(bit_f), .holds(rel_true)
    );

    always_comb begin
        st_d = '0;
        if (req_valid) begin
            if (req_is_jump) begin
                st_d.taken = rel_true;
            end else begin
                st_d.valid = 1'b1;
                st_d.mask  = rel_true ? ONES : '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign res_valid = st_q.valid;
    assign res_mask  = st_q.mask;
    assign br_taken  = st_q.taken;

    // Mask is always uniform
    p_mask_uniform_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (res_mask == '0) || (res_mask == ONES));

    // A jump never leaves a mask behind
    p_jump_no_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
        br_taken |-> (!res_valid && res_mask == '0));

    // Taken only after a jump request
    p_taken_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        br_taken |-> $past(req_valid && req_is_jump));

    // Idle cycle gives quiet outputs
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!res_valid && !br_taken && res_mask == '0));

    // Never relation yields zero
    p_never_false_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_rel == 4'd0) |=> (!br_taken && res_mask == '0));

    // Signed less-than matches a direct signed compare
    p_signed_lt_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_is_jump && req_rel == 4'd4) |=>
        (res_mask[0] == ($signed($past(opnd_a)) < $signed($past(opnd_b)))));
endmodule

// File: tb/test_relmask_unit.sv
module test_relmask_unit;
    localparam int W = 32;

    typedef struct packed {
        logic         valid;
        logic [W-1:0] mask;
        logic         taken;
        logic [3:0]   rel;
        logic         jump;
        logic         req;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_is_jump = 1'b0;
    logic [3:0]   req_rel = '0;
    logic [W-1:0] opnd_a = '0;
    logic [W-1:0] opnd_b = '0;
    logic         res_valid;
    logic [W-1:0] res_mask;
    logic         br_taken;

    int   n_checks = 0;
    int   n_errors = 0;
    bit   done = 1'b0;
    exp_t sb[$];

    relmask_unit #(.WIDTH(W)) i_relmask_unit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .req_is_jump(req_is_jump), .req_rel(req_rel),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .res_valid(res_valid),
        .res_mask(res_mask), .br_taken(br_taken)
    );

    always #5 clk = ~clk;

    function automatic logic model(input logic [3:0] r, input logic [W-1:0] a,
                                   input logic [W-1:0] b);
        case (r)
            4'd0:  return 1'b0;
            4'd1:  return 1'b1;
            4'd2:  return a == b;
            4'd3:  return a != b;
            4'd4:  return $signed(a) <  $signed(b);
            4'd5:  return $signed(a) <= $signed(b);
            4'd6:  return $signed(a) >  $signed(b);
            4'd7:  return $signed(a) >= $signed(b);
            4'd8:  return a <  b;
            4'd9:  return a <= b;
            4'd10: return a >  b;
            4'd11: return a >= b;
            4'd12: return (a & b) != '0;
            4'd13: return (a & b) == '0;
            4'd14: return (a & b) == b;
            default: return (a & b) != b;
        endcase
    endfunction

    function automatic string tag(input exp_t e);
        if (!e.req)     return "R9";
        if (e.jump)     return "R8";
        if (e.rel < 2)  return "R3/R2";
        if (e.rel < 4)  return "R4/R2";
        if (e.rel < 8)  return "R5/R2";
        if (e.rel < 12) return "R6/R2";
        return "R7/R2";
    endfunction

    task automatic drive(input logic v, input logic j, input logic [3:0] r,
                         input logic [W-1:0] a, input logic [W-1:0] b);
        exp_t e;
        logic h;
        @(negedge clk);
        req_valid = v; req_is_jump = j; req_rel = r; opnd_a = a; opnd_b = b;
        h = model(r, a, b);
        e.req   = v;
        e.jump  = j;
        e.rel   = r;
        e.valid = v && !j;
        e.mask  = (v && !j && h) ? '1 : '0;
        e.taken = v && j && h;
        sb.push_back(e);
    endtask

    // monitor: compares one item per cycle after the capturing edge
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            n_checks++;
            if (res_valid !== e.valid || res_mask !== e.mask || br_taken !== e.taken) begin
                n_errors++;
                $display("FAIL %s rel=%0d jump=%0b: got v=%0b m=%h t=%0b exp v=%0b m=%h t=%0b",
                         tag(e), e.rel, e.jump, res_valid, res_mask, br_taken,
                         e.valid, e.mask, e.taken);
            end
        end
    end

    task automatic check_reset;
        n_checks++;
        if (res_valid !== 1'b0 || res_mask !== '0 || br_taken !== 1'b0) begin
            n_errors++;
            $display("FAIL R1: got v=%0b m=%h t=%0b exp 0 0 0", res_valid, res_mask, br_taken);
        end
    endtask

    logic [W-1:0] pat [8];

    initial begin
        pat[0] = 32'h0000_0000; pat[1] = 32'h0000_0001;
        pat[2] = 32'hFFFF_FFFF; pat[3] = 32'h7FFF_FFFF;
        pat[4] = 32'h8000_0000; pat[5] = 32'h8000_0001;
        pat[6] = 32'h5555_5555; pat[7] = 32'hAAAA_AAAA;
        repeat (3) @(negedge clk);
        check_reset();                      // R1 during reset
        rst_n = 1'b1;
        @(negedge clk);
        check_reset();                      // R1 first cycle after reset
        for (int r = 0; r < 16; r++) begin
            for (int k = 0; k < 2; k++) begin
                for (int i = 0; i < 8; i++) begin
                    for (int j = 0; j < 8; j++) begin
                        drive(1'b1, k[0], r[3:0], pat[i], pat[j]);
                    end
                end
                drive(1'b0, 1'b0, r[3:0], pat[r % 8], pat[(r + 3) % 8]); // R9 idle
            end
        end
        // R8: back-to-back jumps, then a set right after a taken jump
        drive(1'b1, 1'b1, 4'd1, '0, '0);
        drive(1'b1, 1'b1, 4'd0, '0, '0);
        drive(1'b1, 1'b1, 4'd1, '0, '0);
        drive(1'b1, 1'b0, 4'd2, 32'h1234_5678, 32'h1234_5678);
        drive(1'b0, 1'b1, 4'd1, '0, '0);    // R9: not valid, jump ignored
        drive(1'b0, 1'b0, 4'd0, '0, '0);
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: got timeout exp completion");
        end
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule